// File: doc/BRIEF.md
# Streaming Serial Word Reader

This block is the read path of a serial-access memory slave with 16-bit words. A host raises chip select and clocks in a start bit, a two-bit operation code and a word address on the serial data input. When the code selects a read, the block fetches the addressed word from a memory read port and begins to shift data out on the serial output.

Before the first word it sends a single dummy zero. It then sends the word MSB first, one bit per rising serial-clock edge. While chip select stays high it steps the address and keeps streaming words with no gap and no further dummy bit. Past the top address it wraps to zero and carries on. Dropping chip select at any point ends the transfer and releases the output.

The serial clock, chip select and data input are sampled in the system clock domain. Serial-clock rising edges must be at least two system clocks apart. Writes, enables and protection live in other blocks, so nothing in this path depends on write-enable state.

Top module: `mw_seq_reader`

## Requirements
- R1: After reset the output enable `sdo_en_o` is 0 and `sdo_o` is 0.
- R2: `sdo_en_o` is 0 whenever chip select is low, and while the command and address bits are still arriving.
- R3: A command is a 1 (start bit), then two code bits, then AW address bits MSB first, each sampled on a rising serial-clock edge with chip select high. Zeros on the data input before the start bit are ignored.
- R4: Code bits other than 1 then 0 leave the output disabled until chip select falls, whatever is clocked in afterwards.
- R5: In the system clock after the edge that samples the last address bit, `sdo_en_o` becomes 1 and `sdo_o` shows one dummy 0 bit.
- R6: On each following rising serial-clock edge, the next bit of the word appears on `sdo_o` one system clock later, MSB first. Between edges `sdo_o` holds its value.
- R7: After bit 0 of a word, the next edge presents the MSB of the word at the next address, with no dummy bit in between.
- R8: The address after 2^AW-1 is 0, and streaming continues.
- R9: Chip select going low disables the output in the next system clock. A later command then starts a fresh read, beginning again with a dummy bit.
- R10: During a read, `mem_addr_o` holds the address of the next word to load. The word is captured from `mem_rdata_i` in the system clock after the address is set, so the memory port is read combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| sdi_i | input | 1 | Serial data input |
| mem_addr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Memory read data for mem_addr_o |
| sdo_o | output | 1 | Serial data output |
| sdo_en_o | output | 1 | Output enable; 0 means high impedance |

## Verification
The hardest case to reach from the ports is a word boundary at the fastest legal serial clock. Here the next word must already be held one system clock after the address step, just before the edge that sends its MSB. The stimulus runs a read with the serial clock high for one system clock and low for one. It starts at the second-highest address and streams four words, so both a back-to-back boundary and the wrap to zero fall under the tightest timing. Other reads use slower clocks, leading zeros, rejected codes and a chip-select drop in the middle of a word.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_CMD,
    RX_GO,
    RX_SKIP
  } rx_state_e;

  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mw_edge_det.sv
module mw_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;

  // a detected edge cannot repeat on the next clock
  assert_rise_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mw_cmd_rx.sv
module mw_cmd_rx
  import mw_rd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rise_i,
  input  logic          sdi_i,
  output logic          go_o,
  output logic [AW-1:0] addr_o
);
  localparam int NBITS = AW + 2;
  localparam int CW    = $clog2(NBITS + 1);
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  rx_state_e      st_q;
  logic [CW-1:0]  cnt_q;
  logic [AW:0]    sr_q;
  logic [AW+1:0]  full;
  logic           last_bit;

  assign full     = {sr_q, sdi_i};
  assign last_bit = cs_i && rise_i && (st_q == RX_CMD) && (cnt_q == LAST);
  assign go_o     = last_bit && (full[AW+1:AW] == OP_READ);
  assign addr_o   = full[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (!cs_i) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
    end else if (rise_i) begin
      unique case (st_q)
        RX_IDLE: if (sdi_i) begin
          st_q  <= RX_CMD;
          cnt_q <= '0;
          sr_q  <= '0;
        end
        RX_CMD: begin
          sr_q  <= full[AW:0];
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST)
            st_q <= (full[AW+1:AW] == OP_READ) ? RX_GO : RX_SKIP;
        end
        default: ;
      endcase
    end
  end

  // once a command is rejected no read starts before chip select falls
  assert_skip_no_go_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_SKIP) |-> !go_o);
endmodule

// File: rtl/mw_read_tx.sv
module mw_read_tx #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rise_i,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          sdo_o,
  output logic          sdo_en_o
);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

  logic          active_q;
  logic          stream_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] pre_q;
  logic [DW-1:0] sh_q;
  logic [BW-1:0] bit_q;
  logic          load_word;

  assign load_word = active_q && rise_i && (!stream_q || bit_q == BIT_LAST);

  // word for addr_q is held one clock after addr_q settles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= mem_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      stream_q <= 1'b0;
      addr_q   <= '0;
      sh_q     <= '0;
      bit_q    <= '0;
    end else if (!cs_i) begin
      active_q <= 1'b0;
      stream_q <= 1'b0;
    end else if (go_i) begin
      active_q <= 1'b1;
      stream_q <= 1'b0;
      addr_q   <= addr_i;
      bit_q    <= '0;
    end else if (load_word) begin
      sh_q     <= pre_q;
      addr_q   <= addr_q + 1'b1;
      bit_q    <= '0;
      stream_q <= 1'b1;
    end else if (active_q && rise_i) begin
      sh_q  <= sh_q << 1;
      bit_q <= bit_q + 1'b1;
    end
  end

  assign mem_addr_o = addr_q;
  assign sdo_o      = stream_q ? sh_q[DW-1] : 1'b0;
  assign sdo_en_o   = active_q;

  // address steps by one per word, wrapping at the top
  assert_addr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !go_i && load_word) |=> (mem_addr_o == $past(mem_addr_o) + 1'b1));

  // output only moves on a serial edge, a new command or a chip-select drop
  assert_hold_between_edges_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !rise_i && !go_i) |=> $stable(sdo_o));
endmodule

// File: rtl/mw_seq_reader.sv
module mw_seq_reader #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sclk_i,
  input  logic          sdi_i,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          sdo_o,
  output logic          sdo_en_o
);
  logic          rise;
  logic          go;
  logic [AW-1:0] cmd_addr;

  mw_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (rise)
  );

  mw_cmd_rx #(.AW(AW)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_i),
    .rise_i (rise),
    .sdi_i  (sdi_i),
    .go_o   (go),
    .addr_o (cmd_addr)
  );

  mw_read_tx #(.AW(AW), .DW(DW)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_i),
    .rise_i      (rise),
    .go_i        (go),
    .addr_i      (cmd_addr),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .sdo_o       (sdo_o),
    .sdo_en_o    (sdo_en_o)
  );

  assert_cs_low_hiz_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !sdo_en_o);

  assert_dummy_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> (sdo_en_o && !sdo_o));

  // a read starts at the address just received
  assert_start_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> (mem_addr_o == $past(cmd_addr)));
endmodule

// File: tb/mw_seq_reader_tb.sv
module mw_seq_reader_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic sdo, sdo_en;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] memf(input int a);
    return DW'((a * 40503 + 7483) ^ (a << 9));
  endfunction

  assign mem_rdata = memf(int'(mem_addr));

  mw_seq_reader #(.AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .sdo_o(sdo), .sdo_en_o(sdo_en)
  );

  // behavioural reference
  int m_st = 0, m_cnt = 0, m_cmd = 0, m_a = 0, m_widx = -1;
  bit m_prev = 0, m_wrapped = 0, e_oe = 0, e_sdo = 0;
  bit m_q[$];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; e_oe = 0; e_sdo = 0; m_q.delete();
    end else if (!cs) begin
      m_st = 0; e_oe = 0; e_sdo = 0; m_q.delete();
    end else if (sclk && !m_prev) begin
      case (m_st)
        0: if (sdi) begin m_st = 1; m_cnt = 0; m_cmd = 0; end
        1: begin
          m_cmd = m_cmd * 2 + int'(sdi);
          m_cnt++;
          if (m_cnt == AW + 2) begin
            if ((m_cmd >> AW) == 2) begin
              m_st = 2; m_a = m_cmd % DEPTH; e_oe = 1; e_sdo = 0;
              m_widx = -1; m_wrapped = 0; m_q.delete();
            end else m_st = 3;
          end
        end
        2: begin
          if (m_q.size() == 0) begin
            logic [DW-1:0] w;
            w = memf(m_a);
            for (int i = DW - 1; i >= 0; i--) m_q.push_back(w[i]);
            m_widx++;
            if (m_a == DEPTH - 1) m_wrapped = 1;
            m_a = (m_a + 1) % DEPTH;
          end
          e_sdo = m_q.pop_front();
        end
        default: ;
      endcase
    end
    m_prev = sclk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    string tag;
    if (!rst_n) tag = "R1";
    else if (m_st == 3) tag = "R4";
    else if (!e_oe) tag = "R2";
    else if (m_widx < 0) tag = "R5";
    else if (m_wrapped) tag = "R8";
    else if (m_widx == 0) tag = "R6";
    else tag = "R7";
    chk(tag, int'(sdo_en), int'(e_oe));
    if (e_oe) chk(tag, int'(sdo), int'(e_sdo));
    if (rst_n && m_st == 2) chk("R10", int'(mem_addr), m_a);
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sbit(input bit d, input int hp);
    @(negedge clk); sdi = d; sclk = 1'b0;
    wait_n(hp - 1);
    @(negedge clk); sclk = 1'b1;
    wait_n(hp - 1);
  endtask

  task automatic send_cmd(input int lead, input bit [1:0] op, input int addr, input int hp);
    @(negedge clk); cs = 1'b1;
    for (int i = 0; i < lead; i++) sbit(1'b0, hp);
    sbit(1'b1, hp);
    sbit(op[1], hp); sbit(op[0], hp);
    for (int i = AW - 1; i >= 0; i--) sbit(addr[i], hp);
  endtask

  task automatic clocks(input int n, input int hp);
    for (int i = 0; i < n; i++) sbit(1'b0, hp);
  endtask

  task automatic drop_cs;
    @(negedge clk); cs = 1'b0; sclk = 1'b0; sdi = 1'b0;
    wait_n(3);
  endtask

  initial begin
    wait_n(3);
    chk("R1", int'(sdo_en), 0);
    chk("R1", int'(sdo), 0);
    rst_n = 1'b1;
    wait_n(3);

    // plain read, three words
    send_cmd(0, 2'b10, 8'h12, 2);
    @(negedge clk);
    chk("R5", int'(sdo_en), 1);
    chk("R5", int'(sdo), 0);
    clocks(3 * DW, 2);
    drop_cs();

    // leading zeros, fastest clock, wrap across the top address
    send_cmd(3, 2'b10, 8'hFE, 1);
    @(negedge clk);
    chk("R3", int'(sdo_en), 1);
    clocks(4 * DW, 1);
    drop_cs();

    // rejected codes stay silent
    send_cmd(0, 2'b11, 8'h33, 2);
    clocks(20, 2);
    @(negedge clk);
    chk("R4", int'(sdo_en), 0);
    drop_cs();
    send_cmd(0, 2'b01, 8'h44, 2);
    clocks(20, 2);
    chk("R4", int'(sdo_en), 0);
    drop_cs();

    // chip-select drop mid word, then a fresh read
    send_cmd(0, 2'b10, 8'h40, 2);
    clocks(7, 2);
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
    chk("R9", int'(sdo_en), 0);
    wait_n(3);
    send_cmd(1, 2'b10, 8'h41, 3);
    @(negedge clk);
    chk("R9", int'(sdo), 0);
    chk("R9", int'(sdo_en), 1);
    clocks(2 * DW + 1, 3);
    drop_cs();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule